// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a 32-bit load/store pipeline, built as pure combinational logic. Each cycle the decode stage hands it an operation code, two register operands, a 16-bit immediate, a flag that selects the immediate in place of the second register, and the floating-point condition bit. The unit returns a 32-bit result, a signed-overflow flag and a branch-taken decision, all within the same cycle.

It covers signed and unsigned addition and subtraction, bitwise AND/OR/XOR, loading an immediate into the upper half of a word, and four branch conditions. Two conditions test the first operand against zero. The other two test the floating-point condition bit. The branch target address is computed elsewhere. A result is always produced, even when overflow is flagged, and the pipeline decides whether to trap.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are 4 bits: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 LHI, 8 BEQZ, 9 BNEZ, 10 BFPT, 11 BFPF. ADD and ADDU return the sum of `src_a` and the second operand modulo 2^32.
- R2: SUB and SUBU return `src_a` minus the second operand modulo 2^32.
- R3: For ADD and SUB, `ovf` is 1 exactly when the two's-complement result lies outside -2^31 .. 2^31-1. The wrapped result is still driven on `result`.
- R4: `ovf` is 0 for ADDU, SUBU and every operation other than ADD and SUB.
- R5: With `imm_sel`=1, the second operand is `imm` sign-extended for ADD and SUB, and `imm` zero-extended for ADDU and SUBU. With `imm_sel`=0 it is `src_b`.
- R6: AND, OR and XOR combine `src_a` bitwise with the second operand. In immediate form (`imm_sel`=1) that operand is `imm` zero-extended.
- R7: LHI returns `imm` in bits 31:16 and zeros in bits 15:0.
- R8: BEQZ sets `br_taken` when `src_a` is zero. BNEZ sets `br_taken` when `src_a` is non-zero.
- R9: BFPT sets `br_taken` when `fp_status` is 1. BFPF sets `br_taken` when `fp_status` is 0.
- R10: `br_taken` is 0 for every non-branch code. Branch codes drive `result` to 0.
- R11: Codes 12 to 15 drive `result`=0, `ovf`=0 and `br_taken`=0.
- R12: LHI and the branch codes give the same outputs whatever the values of `imm_sel` and `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Decoded operation |
| imm_sel | input | 1 | Use immediate as second operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Instruction immediate |
| fp_status | input | 1 | Floating-point condition bit |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow |
| br_taken | output | 1 | Branch condition met |

## Verification
The hardest case to reach is overflow in the signed immediate forms. A negative 16-bit immediate must be sign-extended and then cross the 2^31 boundary together with `src_a`. Only a few operand pairs do this, and the same immediate must not flag overflow under ADDU and SUBU. The sweep pairs boundary words (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) with boundary immediates (0x7FFF, 0x8000, 0xFFFF) for every code in both operand forms. It compares the results against 64-bit signed arithmetic computed in the bench.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [3:0]        op_code,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              fp_status,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              br_taken
);
  localparam int MSB = DATA_W - 1;
  localparam int PAD = DATA_W - IMM_W;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_LHI  = 4'd7;
  localparam logic [3:0] OP_BEQZ = 4'd8;
  localparam logic [3:0] OP_BNEZ = 4'd9;
  localparam logic [3:0] OP_BFPT = 4'd10;
  localparam logic [3:0] OP_BFPF = 4'd11;

  logic              signed_op;
  logic [DATA_W-1:0] imm_sx, imm_zx, opnd_b, sum, diff;
  logic              add_ovf, sub_ovf;

  assign signed_op = (op_code == OP_ADD) || (op_code == OP_SUB);
  assign imm_sx    = {{PAD{imm[IMM_W-1]}}, imm};
  assign imm_zx    = {{PAD{1'b0}}, imm};
  assign opnd_b    = imm_sel ? (signed_op ? imm_sx : imm_zx) : src_b;
  assign sum       = src_a + opnd_b;
  assign diff      = src_a - opnd_b;
  assign add_ovf   = (src_a[MSB] == opnd_b[MSB]) && (sum[MSB]  != src_a[MSB]);
  assign sub_ovf   = (src_a[MSB] != opnd_b[MSB]) && (diff[MSB] != src_a[MSB]);

  always_comb begin
    result   = '0;
    ovf      = 1'b0;
    br_taken = 1'b0;
    unique case (op_code)
      OP_ADD:  begin result = sum;  ovf = add_ovf; end
      OP_ADDU: result = sum;
      OP_SUB:  begin result = diff; ovf = sub_ovf; end
      OP_SUBU: result = diff;
      OP_AND:  result = src_a & opnd_b;
      OP_OR:   result = src_a | opnd_b;
      OP_XOR:  result = src_a ^ opnd_b;
      OP_LHI:  result = {imm, {PAD{1'b0}}};
      OP_BEQZ: br_taken = (src_a == '0);
      OP_BNEZ: br_taken = (src_a != '0);
      OP_BFPT: br_taken = fp_status;
      OP_BFPF: br_taken = ~fp_status;
      default: ;
    endcase
  end

  always_comb begin
    if (ovf)
      p_ovf_signed_only_r4: assert (op_code == OP_ADD || op_code == OP_SUB);
    if (ovf)
      p_ovf_sign_flip_r3: assert (result[MSB] != src_a[MSB]);
    if (br_taken)
      p_branch_only_r10: assert (op_code[3:2] == 2'b10);
    if (op_code == OP_LHI)
      p_lhi_low_zero_r7: assert (result[PAD-1:0] == '0 && result[MSB -: IMM_W] == imm);
    if (op_code[3:2] == 2'b11)
      p_undef_quiet_r11: assert (result == '0 && !ovf && !br_taken);
  end
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic        fp_status = 1'b0;
  logic [31:0] result;
  logic        ovf, br_taken;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .op_code(op_code), .imm_sel(imm_sel), .src_a(src_a), .src_b(src_b),
    .imm(imm), .fp_status(fp_status), .result(result), .ovf(ovf), .br_taken(br_taken)
  );

  function automatic logic [31:0] word_val(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;  3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;  5: return 32'hFFFF_8000;
      6: return 32'h1234_5678;  default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [15:0] imm_val(int i);
    case (i)
      0: return 16'h0000; 1: return 16'h7FFF; 2: return 16'h8000;
      3: return 16'hFFFF; default: return 16'hA5C3;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1: return "R1";  2, 3: return "R2";
      4, 5, 6: return "R6"; 7: return "R7";
      8, 9: return "R8";  10, 11: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d sel=%0b a=%h b=%h imm=%h fp=%0b: got %h expected %h",
               tag, what, op_code, imm_sel, src_a, src_b, imm, fp_status, got, exp);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    check("R1", "reset result", result, 32'h0);
    check("R3", "reset ovf", {31'b0, ovf}, 32'h0);
    check("R10", "reset br", {31'b0, br_taken}, 32'h0);
    rst_n = 1'b1;

    for (int op = 0; op < 16; op++)
      for (int sel = 0; sel < 2; sel++)
        for (int ia = 0; ia < 8; ia++)
          for (int ib = 0; ib < 8; ib++)
            for (int ii = 0; ii < 5; ii++)
              for (int fp = 0; fp < 2; fp++) begin
                logic [31:0] b_eff, e_res;
                logic        e_ovf, e_br;
                longint      sa, sb, t;
                @(posedge clk);
                op_code = op[3:0]; imm_sel = sel[0];
                src_a = word_val(ia); src_b = word_val(ib);
                imm = imm_val(ii); fp_status = fp[0];
                // R5: operand selection and extension
                if (sel == 0) b_eff = src_b;
                else if (op == 0 || op == 2) b_eff = {{16{imm[15]}}, imm};
                else b_eff = {16'h0, imm};
                sa = longint'($signed(src_a)); sb = longint'($signed(b_eff));
                e_res = 32'h0; e_ovf = 1'b0; e_br = 1'b0;
                case (op)
                  0: begin t = sa + sb; e_res = 32'(t);
                       e_ovf = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
                  1: e_res = 32'(sa + sb);
                  2: begin t = sa - sb; e_res = 32'(t);
                       e_ovf = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
                  3: e_res = 32'(sa - sb);
                  4: e_res = src_a & b_eff;
                  5: e_res = src_a | b_eff;
                  6: e_res = src_a ^ b_eff;
                  7: e_res = {imm, 16'h0};
                  8: e_br = (src_a == 0);
                  9: e_br = (src_a != 0);
                  10: e_br = fp_status;
                  11: e_br = !fp_status;
                  default: ;
                endcase
                @(negedge clk);
                vectors++;
                check((sel == 1 && op < 4) ? "R5" : (op >= 7 && op <= 11 ? "R12" : tag_of(op)),
                      "result", result, e_res);
                check((op == 0 || op == 2) ? "R3" : "R4", "ovf", {31'b0, ovf}, {31'b0, e_ovf});
                check((op >= 8 && op <= 11) ? tag_of(op) : "R10", "br_taken",
                      {31'b0, br_taken}, {31'b0, e_br});
              end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule